// File: doc/BRIEF.md
# 8b/10b Transmit Encoder with Per-Character Disparity Control

This block turns a word of two or four bytes into a word of 10-bit line symbols. Each byte comes with a flag that marks it as a control character. Each byte also has a two-bit disparity control. The block keeps one running disparity (RD). The RD passes through the byte lanes from lane 0 upward, and the RD after the last lane carries into the next word. In the automatic setting, each lane picks its symbol from the RD it receives. The other settings replace that RD for one character: they can invert it, force it negative or force it positive. This lets a protocol send a character with chosen polarity, for example an idle character with reversed disparity.

Words enter on a valid/ready handshake. An input word is taken on a rising clock edge when `in_valid` and `in_ready` are both high. Its coded word appears on the output one cycle later. The output holds one word. While `out_valid` is high and `out_ready` is low, that word and its error flags are held unchanged, and `in_ready` is low. So back-pressure reaches the source in the same cycle, with no extra buffering. `in_ready` is high whenever the output register is empty or is being drained in that cycle.

Top module: `enc8b10b_tx`

## Requirements
- R1: A word is taken when `in_valid` and `in_ready` are both high at a clock edge, and it appears on `out_code`/`out_kerr` with `out_valid` on the next edge. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_code` and `out_kerr` do not change, and `in_ready` is low.
- R2: After reset, `out_valid` is 0 and `in_ready` is 1. The RD is negative, so the first lane of the first word is encoded as if RD were negative.
- R3: Byte n is `in_data[8n+7:8n]` and its symbol is `out_code[10n+9:10n]`. Within a symbol, bit 0 is a, and bits 1 to 9 are b, c, d, e, i, f, g, h, j. So the order from MSB to LSB is j h g f i e d c b a.
- R4: Data bytes use the standard 5b/6b and 3b/4b tables. Every symbol holds four, five or six ones.
- R5: With lane control 00, a lane encodes using the RD left by the lane below it. Lane 0 uses the RD left by the last lane of the previous word.
- R6: For data bytes with HGF = 7, the alternate 4-bit code is used when the primary code would give a run of five equal bits. This happens for x = 17, 18, 20 when RD is negative and for x = 11, 13, 14 when RD is positive.
- R7: Lane control 01 encodes the character with the inverse of the RD the lane receives.
- R8: Lane control 10 encodes the character as if RD were negative.
- R9: Lane control 11 encodes the character as if RD were positive.
- R10: The RD after a symbol comes from that symbol's actual weight, including symbols set by a lane control. More than five ones gives positive, fewer than five gives negative, and exactly five leaves the RD as it was.
- R11: A control-flagged byte of 0x1C, 0x3C, 0x5C, 0x7C, 0x9C, 0xBC, 0xDC, 0xFC, 0xF7, 0xFB, 0xFD or 0xFE is encoded as the matching K character.
- R12: A control-flagged byte outside the R11 list sets that lane's bit of `out_kerr`. The lane still outputs the data symbol of that byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can take a word this cycle |
| in_data | input | 8*LANES | Bytes; lane 0 in the low byte |
| in_ctrl | input | LANES | Per-lane control-character flag |
| in_disp | input | 2*LANES | Per-lane disparity control; lane n at [2n+1:2n], 00 auto, 01 invert, 10 negative, 11 positive |
| out_valid | output | 1 | Coded word present |
| out_ready | input | 1 | Sink takes the coded word this cycle |
| out_code | output | 10*LANES | Coded symbols; symbol 0 in the low ten bits |
| out_kerr | output | LANES | Per-lane invalid control-character flag |

## Verification
The bench targets the places where an RD error spreads. It chains K28.5 symbols across lanes and across words. If the chain broke at a lane or word boundary, two symbols of the same polarity would appear in a row. It drives forced and inverted lane controls next to automatic lanes. A design that took the next RD from the selected polarity, and not from the symbol actually sent, would emit wrong codes in the following lane. It also covers D11.7, D17.7 and D3.3 at both polarities, where a missing alternate code or a missing flip of the balanced x.3 code would show up as a wrong symbol. Finally, it applies random back-pressure, so a design that let the output register change while stalled, or dropped a word, would be detected.

// File: rtl/enc8b10b_pkg.sv
package enc8b10b_pkg;

  typedef enum logic [1:0] {
    DM_AUTO = 2'b00,
    DM_FLIP = 2'b01,
    DM_NEG  = 2'b10,
    DM_POS  = 2'b11
  } disp_mode_e;

  // 6-bit sub-block for negative RD, written abcdei with a as MSB
  function automatic logic [5:0] code6_neg(input logic [4:0] x);
    logic [5:0] c;
    case (x)
      5'd0:  c = 6'b100111;  5'd1:  c = 6'b011101;
      5'd2:  c = 6'b101101;  5'd3:  c = 6'b110001;
      5'd4:  c = 6'b110101;  5'd5:  c = 6'b101001;
      5'd6:  c = 6'b011001;  5'd7:  c = 6'b111000;
      5'd8:  c = 6'b111001;  5'd9:  c = 6'b100101;
      5'd10: c = 6'b010101;  5'd11: c = 6'b110100;
      5'd12: c = 6'b001101;  5'd13: c = 6'b101100;
      5'd14: c = 6'b011100;  5'd15: c = 6'b010111;
      5'd16: c = 6'b011011;  5'd17: c = 6'b100011;
      5'd18: c = 6'b010011;  5'd19: c = 6'b110010;
      5'd20: c = 6'b001011;  5'd21: c = 6'b101010;
      5'd22: c = 6'b011010;  5'd23: c = 6'b111010;
      5'd24: c = 6'b110011;  5'd25: c = 6'b100110;
      5'd26: c = 6'b010110;  5'd27: c = 6'b110110;
      5'd28: c = 6'b001110;  5'd29: c = 6'b101110;
      5'd30: c = 6'b011110;  default: c = 6'b101011;
    endcase
    return c;
  endfunction

  // 4-bit sub-block for negative RD, written fghj with f as MSB
  function automatic logic [3:0] code4_neg(input logic [2:0] y, input logic alt);
    logic [3:0] c;
    case (y)
      3'd0: c = 4'b1011;
      3'd1: c = 4'b1001;
      3'd2: c = 4'b0101;
      3'd3: c = 4'b1100;
      3'd4: c = 4'b1101;
      3'd5: c = 4'b1010;
      3'd6: c = 4'b0110;
      default: c = alt ? 4'b0111 : 4'b1110;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/enc_kcheck.sv
module enc_kcheck (
  input  logic [7:0] byte_i,
  output logic       k_legal_o
);
  logic [4:0] x;
  logic [2:0] y;
  assign x = byte_i[4:0];
  assign y = byte_i[7:5];

  always_comb begin
    k_legal_o = (x == 5'd28);
    if (y == 3'd7 && (x == 5'd23 || x == 5'd27 || x == 5'd29 || x == 5'd30))
      k_legal_o = 1'b1;
  end
endmodule

// File: rtl/enc_lane.sv
module enc_lane
  import enc8b10b_pkg::*;
(
  input  logic       [7:0] byte_i,
  input  logic             ctrl_i,
  input  disp_mode_e       disp_i,
  input  logic             rd_i,
  output logic       [9:0] sym_o,
  output logic             rd_o,
  output logic             kerr_o
);
  logic [4:0] x;
  logic [2:0] y;
  logic       k_legal, k_use, rd_sel, rd_mid, six_unbal, four_unbal, use_alt;
  logic [5:0] six_base, six;
  logic [3:0] four_base, four;
  logic [9:0] lit;
  int unsigned wt;

  assign x = byte_i[4:0];
  assign y = byte_i[7:5];

  enc_kcheck u_kchk (.byte_i(byte_i), .k_legal_o(k_legal));

  assign k_use  = ctrl_i && k_legal;
  assign kerr_o = ctrl_i && !k_legal;

  always_comb begin
    case (disp_i)
      DM_AUTO: rd_sel = rd_i;
      DM_FLIP: rd_sel = !rd_i;
      DM_NEG:  rd_sel = 1'b0;
      default: rd_sel = 1'b1;
    endcase
  end

  always_comb begin
    six_base  = (k_use && x == 5'd28) ? 6'b001111 : code6_neg(x);
    six_unbal = ($countones(six_base) != 3);
    six       = ((six_unbal || x == 5'd7) && rd_sel) ? ~six_base : six_base;
    rd_mid    = six_unbal ? !rd_sel : rd_sel;
    use_alt   = (y == 3'd7) &&
                (k_use ||
                 (!rd_mid && (x == 5'd17 || x == 5'd18 || x == 5'd20)) ||
                 ( rd_mid && (x == 5'd11 || x == 5'd13 || x == 5'd14)));
    four_base  = code4_neg(y, use_alt);
    four_unbal = ($countones(four_base) != 2);
    if (four_unbal || y == 3'd3)
      four = rd_mid ? ~four_base : four_base;
    else
      four = (k_use && !rd_mid) ? ~four_base : four_base;
    lit = {six, four};
    for (int i = 0; i < 10; i++) sym_o[i] = lit[9-i];
  end

  always_comb begin
    wt = $countones(sym_o);
    if (wt > 5)      rd_o = 1'b1;
    else if (wt < 5) rd_o = 1'b0;
    else             rd_o = rd_i;
  end
endmodule

// File: rtl/enc_out_reg.sv
module enc_out_reg #(
  parameter int W = 44
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] d,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] q
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      q         <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) q <= d;
    end
  end
endmodule

// File: rtl/enc8b10b_tx.sv
module enc8b10b_tx
  import enc8b10b_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [8*LANES-1:0]    in_data,
  input  logic [LANES-1:0]      in_ctrl,
  input  logic [2*LANES-1:0]    in_disp,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [10*LANES-1:0]   out_code,
  output logic [LANES-1:0]      out_kerr
);
  localparam int CW = 10 * LANES;
  localparam int PW = CW + LANES;

  logic             rd_q, accept;
  logic [LANES:0]   rd_ch;
  logic [CW-1:0]    code_d;
  logic [LANES-1:0] err_d;
  logic [PW-1:0]    q_w;

  assign rd_ch[0] = rd_q;
  assign accept   = in_valid && in_ready;

  for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
    disp_mode_e dm;
    assign dm = disp_mode_e'(in_disp[2*gi +: 2]);

    enc_lane u_lane (
      .byte_i (in_data[8*gi +: 8]),
      .ctrl_i (in_ctrl[gi]),
      .disp_i (dm),
      .rd_i   (rd_ch[gi]),
      .sym_o  (code_d[10*gi +: 10]),
      .rd_o   (rd_ch[gi+1]),
      .kerr_o (err_d[gi])
    );

    assert_sym_weight_R4: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> ($countones(code_d[10*gi +: 10]) >= 4 &&
                  $countones(code_d[10*gi +: 10]) <= 6));

    assert_auto_polarity_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && dm == DM_AUTO) |->
        (rd_ch[gi] ? $countones(code_d[10*gi +: 10]) <= 5
                   : $countones(code_d[10*gi +: 10]) >= 5));

    assert_flip_polarity_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && dm == DM_FLIP) |->
        (rd_ch[gi] ? $countones(code_d[10*gi +: 10]) >= 5
                   : $countones(code_d[10*gi +: 10]) <= 5));

    assert_force_neg_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && dm == DM_NEG) |-> $countones(code_d[10*gi +: 10]) >= 5);

    assert_force_pos_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && dm == DM_POS) |-> $countones(code_d[10*gi +: 10]) <= 5);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_q <= 1'b0;
    else if (accept) rd_q <= rd_ch[LANES];
  end

  enc_out_reg #(.W(PW)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .d         ({err_d, code_d}),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .q         (q_w)
  );

  assign out_code = q_w[CW-1:0];
  assign out_kerr = q_w[PW-1:CW];

  assert_hold_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_code) && $stable(out_kerr)));

  assert_stall_blocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

// File: tb/test_enc8b10b_tx.sv
module test_enc8b10b_tx;
  localparam int L = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic            rst_n, in_valid, in_ready, out_valid, out_ready;
  logic [8*L-1:0]  in_data;
  logic [L-1:0]    in_ctrl, out_kerr;
  logic [2*L-1:0]  in_disp;
  logic [10*L-1:0] out_code;

  enc8b10b_tx #(.LANES(L)) i_enc8b10b_tx (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_ctrl(in_ctrl), .in_disp(in_disp),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_code(out_code), .out_kerr(out_kerr));

  int n_cmp = 0, n_bad = 0;
  logic brd;
  logic bp_on = 1'b0;
  logic [10*L-1:0] exp_code_q[$];
  logic [L-1:0]    exp_err_q[$];
  string           tag_q[$];
  logic [7:0] chars [10] = '{8'h00, 8'hB5, 8'hBC, 8'hF1, 8'hEB,
                              8'hFC, 8'hF7, 8'h07, 8'h4A, 8'h63};

  // Literal abcdeifghj (a at MSB) for the characters the bench uses
  function automatic logic [9:0] ref_lit(input logic [7:0] b, input logic k, input logic rd);
    case ({k, b})
      9'h000: return rd ? 10'b0110001011 : 10'b1001110100;
      9'h0B5: return 10'b1010101010;
      9'h1BC: return rd ? 10'b1100000101 : 10'b0011111010;
      9'h0BC: return 10'b0011101010;
      9'h0F1: return rd ? 10'b1000110001 : 10'b1000110111;
      9'h0EB: return rd ? 10'b1101001000 : 10'b1101001110;
      9'h1FC: return rd ? 10'b1100000111 : 10'b0011111000;
      9'h0FC: return rd ? 10'b0011100001 : 10'b0011101110;
      9'h1F7: return rd ? 10'b0001010111 : 10'b1110101000;
      9'h0F7: return rd ? 10'b0001011110 : 10'b1110100001;
      9'h007: return rd ? 10'b0001110100 : 10'b1110001011;
      9'h04A: return 10'b0101010101;
      9'h063: return rd ? 10'b1100010011 : 10'b1100011100;
      default: return 10'b0;
    endcase
  endfunction

  function automatic logic [9:0] to_sym(input logic [9:0] lit);
    logic [9:0] s;
    for (int i = 0; i < 10; i++) s[i] = lit[9-i];
    return s;
  endfunction

  function automatic logic k_known(input logic [7:0] b);
    return (b == 8'hBC) || (b == 8'hFC) || (b == 8'hF7);
  endfunction

  task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic send(input logic [8*L-1:0] d, input logic [L-1:0] k,
                      input logic [2*L-1:0] ds, input string tag);
    logic [10*L-1:0] ec;
    logic [L-1:0]    ee;
    for (int n = 0; n < L; n++) begin
      logic [7:0] b;
      logic ke, sel;
      logic [9:0] s;
      int w;
      b  = d[8*n +: 8];
      ke = k[n] && k_known(b);
      ee[n] = k[n] && !ke;
      case (ds[2*n +: 2])
        2'b00:   sel = brd;
        2'b01:   sel = !brd;
        2'b10:   sel = 1'b0;
        default: sel = 1'b1;
      endcase
      s = to_sym(ref_lit(b, ke, sel));
      ec[10*n +: 10] = s;
      w = $countones(s);
      if (w > 5) brd = 1'b1;
      else if (w < 5) brd = 1'b0;
    end
    exp_code_q.push_back(ec);
    exp_err_q.push_back(ee);
    tag_q.push_back(tag);
    @(negedge clk);
    in_data = d; in_ctrl = k; in_disp = ds; in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  // back-pressure driver
  always @(negedge clk) out_ready <= bp_on ? ($urandom_range(0, 2) != 0) : 1'b1;

  // monitor / scoreboard
  logic prev_stall = 1'b0;
  logic [10*L+L-1:0] prev_word;
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n) begin
        if (prev_stall)
          check(out_valid && {out_kerr, out_code} == prev_word, "R1 held word while stalled",
                {out_kerr, out_code}, prev_word);
        if (out_valid && out_ready) begin
          if (exp_code_q.size() == 0) begin
            check(1'b0, "R1 unexpected output word", out_code, 0);
          end else begin
            logic [10*L-1:0] ec;
            logic [L-1:0] ee;
            string t;
            ec = exp_code_q.pop_front();
            ee = exp_err_q.pop_front();
            t  = tag_q.pop_front();
            check(out_code == ec && out_kerr == ee, t, {out_kerr, out_code}, {ee, ec});
            for (int n = 0; n < L; n++)
              check($countones(out_code[10*n +: 10]) inside {[4:6]}, "R4 symbol weight",
                    out_code[10*n +: 10], 0);
          end
          prev_stall = 1'b0;
        end else if (out_valid) begin
          prev_stall = 1'b1;
          prev_word  = {out_kerr, out_code};
        end else begin
          prev_stall = 1'b0;
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog: actual=hung expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_ctrl = '0; in_disp = '0;
    brd = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(out_valid == 1'b0, "R2 out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R2 in_ready after reset", in_ready, 1);

    // R2 R3 R4: first word from negative RD, lanes placed low byte first
    send({8'h07, 8'hBC, 8'hB5, 8'h00}, 4'b0100, 8'h00, "R2 R3 R4 first word");
    // R5: K28.5 chain across lanes and words
    repeat (3) send({4{8'hBC}}, 4'hF, 8'h00, "R5 K28.5 chain");
    send({8'h63, 8'h07, 8'h63, 8'h07}, 4'h0, 8'h00, "R5 R4 balanced flip codes");
    // R6: alternate codes at both polarities
    send({8'hF1, 8'hEB, 8'hF1, 8'hEB}, 4'h0, {2'b11, 2'b10, 2'b10, 2'b11}, "R6 alternate x.7");
    send({8'hEB, 8'hF1, 8'hEB, 8'hF1}, 4'h0, 8'h00, "R6 alternate x.7 chained");
    // R7 R8 R9
    send({4{8'hBC}}, 4'hF, {4{2'b01}}, "R7 invert");
    send({8'h63, 8'hBC, 8'h00, 8'h07}, 4'b0100, {4{2'b10}}, "R8 force negative");
    send({8'h63, 8'hBC, 8'h00, 8'h07}, 4'b0100, {4{2'b11}}, "R9 force positive");
    // R10: forced symbol drives RD of next lane
    send({8'h63, 8'hF7, 8'h00, 8'hBC}, 4'b0101, {2'b00, 2'b10, 2'b00, 2'b11}, "R10 RD from forced symbol");
    // R11
    send({8'hFC, 8'hF7, 8'hFC, 8'hF7}, 4'hF, 8'h00, "R11 K28.7 K23.7");
    send({8'hF7, 8'hFC, 8'hBC, 8'hF7}, 4'hF, 8'h00, "R11 K mixed");
    // R12
    send({8'hF1, 8'h00, 8'hBC, 8'h4A}, 4'hF, 8'h00, "R12 illegal control flag");

    // R1: random words under back-pressure
    bp_on = 1'b1;
    for (int i = 0; i < 150; i++) begin
      logic [8*L-1:0] d;
      for (int n = 0; n < L; n++) d[8*n +: 8] = chars[$urandom_range(0, 9)];
      send(d, L'($urandom), (2*L)'($urandom), "R1 R5 R10 random under back-pressure");
    end
    bp_on = 1'b0;
    repeat (20) @(posedge clk);
    check(exp_code_q.size() == 0, "R1 all words delivered", exp_code_q.size(), 0);
    finish_run();
  end
endmodule